// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master of an Ethernet MAC. It runs clause-22 register reads and writes to an external PHY. Software first loads a 16-bit data register when it wants a write. It then writes a 24-bit command word that carries the PHY address, the register address, the direction, a preamble-skip flag, a clock divider and a start flag. The block produces the MDC clock and shifts one management frame out on MDIO. During a read it releases the line through an output-enable and collects the PHY's reply.

The start flag doubles as the busy indication and clears itself when the frame ends, so software only polls it. After a read, the captured 16-bit value appears in the data register. MDC runs only while the MAC-level clock enable input is high. If that input drops in the middle of a frame, the frame simply pauses.

Top module: `mdio_master`

## Requirements
- R1: Command word layout: bits [4:0] register address, [12:8] PHY address, bit 16 write (1) or read (0), bit 17 start/busy, bit 18 preamble skip, bits [23:19] divider. A write while idle stores every field and reads back at the same positions on `ctrl_rdata`; unused bits read 0. A write with bit 17 clear starts nothing.
- R2: A command write with bit 17 set while idle starts a frame. `ctrl_rdata[17]` reads 1 until the frame ends, then 0. It falls on the same clock edge as the last falling edge of MDC.
- R3: The frame is sent MSB first: 32 preamble ones, start `01`, opcode `01` for write or `10` for read, 5-bit PHY address, 5-bit register address, a 2-bit turnaround (`10` when writing), then 16 data bits.
- R4: With bit 18 set the preamble is omitted, giving 32 MDC pulses instead of 64.
- R5: The MDC period is 4 × (divider + 1) system clocks, with equal high and low phases. MDC is low while idle.
- R6: When writing, MDIO is driven for the whole frame. It changes only at a falling edge of MDC and holds steady while MDC is high.
- R7: When reading, the output-enable drops at the turnaround and stays low through the data field. Data bits are sampled at MDC rising edges, and the 16-bit result is on `data_rdata` once busy clears.
- R8: While `mdc_en` is low, MDC holds its level and the frame does not advance. It resumes when `mdc_en` returns.
- R9: Command and data writes made while busy are ignored. Stored fields, the frame in flight and the data register are all unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_en | input | 1 | MAC-level enable for MDC generation |
| ctrl_we | input | 1 | Command word write strobe |
| ctrl_wdata | input | 24 | Command word write value |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write value |
| ctrl_rdata | output | 24 | Command word readback including busy |
| data_rdata | output | 16 | Data register readback (write data or read result) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that `mdio_i` is only meaningful while the block has released the line. They also assume register strobes may arrive at any time, including mid-frame, and they check that such strobes have no effect. The stimulus changes `mdio_i` only just after MDC falls, which keeps the read data stable around each rising edge. It drops `mdc_en` only for whole stretches of cycles. It sweeps every combination of divider 0 to 3, preamble skip and direction, then adds a stall case and a mid-frame write case.

// File: rtl/mdio_master.sv
module mdio_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdc_en,
  input  logic        ctrl_we,
  input  logic [23:0] ctrl_wdata,
  input  logic        data_we,
  input  logic [15:0] data_wdata,
  output logic [23:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PRE_BITS = 32;
  localparam int TA_POS   = PRE_BITS + 14;
  localparam int DAT_POS  = PRE_BITS + 16;
  localparam int LAST_POS = PRE_BITS + 31;

  logic [4:0]  reg_a, phy_a, div_q;
  logic        wr_q, skip_q, busy_q, mdc_q;
  logic [15:0] data_q, rsh_q;
  logic [31:0] frame_q;
  logic [5:0]  idx_q, cnt_q;
  logic [5:0]  half_m1;

  assign half_m1 = {div_q, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= '0; phy_a <= '0; div_q <= '0;
      wr_q <= 1'b0; skip_q <= 1'b0; busy_q <= 1'b0; mdc_q <= 1'b0;
      data_q <= '0; rsh_q <= '0; frame_q <= '0; idx_q <= '0; cnt_q <= '0;
    end else if (!busy_q) begin
      if (data_we) data_q <= data_wdata;
      if (ctrl_we) begin
        reg_a  <= ctrl_wdata[4:0];
        phy_a  <= ctrl_wdata[12:8];
        wr_q   <= ctrl_wdata[16];
        skip_q <= ctrl_wdata[18];
        div_q  <= ctrl_wdata[23:19];
        if (ctrl_wdata[17]) begin
          busy_q  <= 1'b1;
          idx_q   <= ctrl_wdata[18] ? 6'd32 : 6'd0;
          cnt_q   <= '0;
          mdc_q   <= 1'b0;
          frame_q <= {2'b01, ctrl_wdata[16] ? 2'b01 : 2'b10,
                      ctrl_wdata[12:8], ctrl_wdata[4:0],
                      ctrl_wdata[16] ? 2'b10 : 2'b00,
                      ctrl_wdata[16] ? (data_we ? data_wdata : data_q) : 16'h0};
        end
      end
    end else if (mdc_en) begin
      if (cnt_q == half_m1) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (!wr_q && idx_q >= 6'(DAT_POS)) rsh_q <= {rsh_q[14:0], mdio_i};
        end else if (idx_q == 6'(LAST_POS)) begin
          busy_q <= 1'b0;
          if (!wr_q) data_q <= rsh_q;
        end else begin
          idx_q <= idx_q + 6'd1;
          if (idx_q >= 6'(PRE_BITS)) frame_q <= frame_q << 1;
        end
      end else begin
        cnt_q <= cnt_q + 6'd1;
      end
    end
  end

  assign mdc        = mdc_q;
  assign mdio_oe    = busy_q && (wr_q || idx_q < 6'(TA_POS));
  assign mdio_o     = busy_q && ((idx_q < 6'(PRE_BITS)) || frame_q[31]);
  assign data_rdata = data_q;
  assign ctrl_rdata = {div_q, skip_q, busy_q, wr_q, 3'b000, phy_a, 3'b000, reg_a};

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[17] |-> !mdc && !mdio_oe);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[17] && !mdc_en |=> $stable(mdc) && $stable(mdio_o) && $stable(mdio_oe));
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[17] && (ctrl_we || data_we) |=> $stable(ctrl_rdata[16:0]) && $stable(data_rdata));
  p_drive_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe && mdc && $past(mdc) |-> $stable(mdio_o));
  p_release_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) && ctrl_rdata[17] |-> !ctrl_rdata[16]);
  p_done_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rdata[17]) |-> $past(mdc) && !mdc);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic clk = 1'b0, rst_n = 1'b0, mdc_en = 1'b1;
  logic ctrl_we = 1'b0, data_we = 1'b0, mdio_i = 1'b0;
  logic [23:0] ctrl_wdata = '0;
  logic [15:0] data_wdata = '0;
  logic [23:0] ctrl_rdata;
  logic [15:0] data_rdata;
  logic mdc, mdio_o, mdio_oe;

  mdio_master u_dut (.clk(clk), .rst_n(rst_n), .mdc_en(mdc_en), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .data_we(data_we), .data_wdata(data_wdata),
    .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int cyc = 0, rises = 0, base = 0, last_rise = 0, per_bad = 0, edge_bad = 0;
  logic bo [0:4095];
  logic boe [0:4095];
  logic mdc_d = 1'b0, mo_d = 1'b0;
  int cur_div = 0;
  logic cur_skip = 1'b0;
  logic [15:0] cur_rd = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (mdc && !mdc_d) begin
      bo[rises % 4096] = mdio_o;
      boe[rises % 4096] = mdio_oe;
      if (rises > base && (cyc - last_rise) != 4 * (cur_div + 1)) per_bad++;
      last_rise = cyc;
      rises++;
    end
    if (!mdc && mdc_d) begin
      int j;
      j = rises - base - (cur_skip ? 0 : 32);
      if (j >= 16 && j < 32) mdio_i <= cur_rd[31 - j];
    end
    if (mdc && mdc_d && mdio_oe && mdio_o != mo_d) edge_bad++;
    mdc_d = mdc;
    mo_d = mdio_o;
  end

  task automatic wait_idle();
    int n = 0;
    while (ctrl_rdata[17] && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [23:0] cmd(input int div, input bit skip, input bit wr,
                                      input bit go, input logic [4:0] phy, input logic [4:0] rg);
    return {5'(div), skip, go, wr, 3'b000, phy, 3'b000, rg};
  endfunction

  task automatic start(input int div, input bit skip, input bit wr,
                       input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
    @(negedge clk);
    cur_div = div; cur_skip = skip; cur_rd = val;
    base = rises; per_bad = 0; edge_bad = 0;
    data_we = wr; data_wdata = val;
    ctrl_we = 1'b1; ctrl_wdata = cmd(div, skip, wr, 1'b1, phy, rg);
    @(negedge clk);
    ctrl_we = 1'b0; data_we = 1'b0;
  endtask

  task automatic verify(input bit skip, input bit wr, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] val);
    logic [31:0] fr;
    int n, off;
    bit ok;
    fr = {2'b01, wr ? 2'b01 : 2'b10, phy, rg, wr ? 2'b10 : 2'b00, val};
    off = skip ? 0 : 32;
    n = rises - base;
    check(n == (skip ? 32 : 64), "R4 pulse count", n, skip ? 32 : 64);
    ok = 1'b1;
    for (int k = 0; k < n && k < 64; k++) begin
      int j;
      bit eoe;
      logic e;
      j = k - off;
      eoe = wr || j < 14;
      e = (k < off) ? 1'b1 : fr[31 - j];
      if (boe[(base + k) % 4096] !== eoe) ok = 1'b0;
      if (eoe && bo[(base + k) % 4096] !== e) ok = 1'b0;
    end
    check(ok, wr ? "R3 write frame" : "R7 read frame/release", 0, 1);
    check(per_bad == 0, "R5 mdc period", per_bad, 0);
    check(!mdc && !mdio_oe, "R5 idle mdc low", mdc, 0);
    check(ctrl_rdata[17] == 1'b0, "R2 busy cleared", ctrl_rdata[17], 0);
    if (wr) check(edge_bad == 0, "R6 change on falling edge", edge_bad, 0);
    check(data_rdata == val, wr ? "R6 data kept" : "R7 read result", data_rdata, val);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ctrl_rdata == 24'h0 && data_rdata == 16'h0 && !mdc && !mdio_oe,
          "R1 reset state", ctrl_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    ctrl_we = 1'b1; ctrl_wdata = cmd(21, 1'b1, 1'b1, 1'b0, 5'h13, 5'h0A) | 24'h00E0E0;
    @(negedge clk);
    ctrl_we = 1'b0;
    @(negedge clk);
    check(ctrl_rdata == cmd(21, 1'b1, 1'b1, 1'b0, 5'h13, 5'h0A), "R1 field readback",
          ctrl_rdata, cmd(21, 1'b1, 1'b1, 1'b0, 5'h13, 5'h0A));
    check(!mdc && rises == 0, "R1 no start without bit 17", rises, 0);

    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++) begin
          logic [4:0] phy, rg;
          logic [15:0] val;
          phy = 5'((d * 7 + s * 11 + w * 5 + 1) % 32);
          rg  = 5'((d * 13 + s * 3 + w * 17 + 2) % 32);
          val = 16'(16'hA5C3 ^ (d * 4099 + s * 771 + w * 12345));
          start(d, s[0], w[0], phy, rg, val);
          check(ctrl_rdata[17] == 1'b1, "R2 busy set", ctrl_rdata[17], 1);
          wait_idle();
          verify(s[0], w[0], phy, rg, val);
        end

    mdc_en = 1'b0;
    start(1, 1'b1, 1'b1, 5'h05, 5'h11, 16'h1234);
    repeat (40) @(negedge clk);
    check(!mdc && ctrl_rdata[17] && rises == base, "R8 stall holds", rises - base, 0);
    mdc_en = 1'b1;
    repeat (30) @(negedge clk);
    mdc_en = 1'b0;
    begin
      int r0;
      logic m0;
      r0 = rises; m0 = mdc;
      repeat (50) @(negedge clk);
      check(rises == r0 && mdc == m0 && ctrl_rdata[17], "R8 mid-frame stall", rises - r0, 0);
    end
    mdc_en = 1'b1;
    wait_idle();
    per_bad = 0;
    verify(1'b1, 1'b1, 5'h05, 5'h11, 16'h1234);

    start(0, 1'b0, 1'b1, 5'h1E, 5'h03, 16'hBEEF);
    repeat (20) @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = cmd(3, 1'b1, 1'b0, 1'b1, 5'h01, 5'h02);
    data_we = 1'b1; data_wdata = 16'h0F0F;
    @(negedge clk);
    ctrl_we = 1'b0; data_we = 1'b0;
    @(negedge clk);
    check(ctrl_rdata[16:0] == cmd(0, 1'b0, 1'b1, 1'b0, 5'h1E, 5'h03) && data_rdata == 16'hBEEF,
          "R9 busy writes ignored", ctrl_rdata, cmd(0, 1'b0, 1'b1, 1'b1, 5'h1E, 5'h03));
    wait_idle();
    verify(1'b0, 1'b1, 5'h1E, 5'h03, 16'hBEEF);
    check(ctrl_rdata[23:19] == 5'd0, "R9 divider kept", ctrl_rdata[23:19], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule